// File: doc/BRIEF.md
# Programmable Wait-State Generator

This block lengthens processor bus cycles so that slow memories and peripherals can be reached. When the bus cycle sequencer strobes the start of an access, the block captures a two-bit wait selector, which software sets in the processor status word. It also captures a slow-region flag produced by an external address decoder. If the access is flagged, the selector picks a programmed number of wait clocks. If the access is not flagged, no programmed waits are added.

Once the programmed count has run out, the external ready line is examined. Every clock in which ready is low adds one more wait clock, with no upper limit. While the cycle is being stretched, the block holds the sequencer with a stall output. It ends each access with a done pulse that lasts one clock. A start strobe that arrives while an access is still open is ignored.

Top module: `wait_stretch`

## Requirements
- R1: During reset and in the first clock after reset is released, `stall` and `done` are both low and the block is idle.
- R2: A flagged access (`slow_rgn`=1) with `wait_sel`=2'b00 gets 4 programmed wait clocks. With `rdy` high, `stall` is high in the 4 clocks that follow the start clock, and `done` is high in the 5th clock.
- R3: For flagged accesses, `wait_sel`=2'b01 gives 2 wait clocks, 2'b10 gives 1 wait clock and 2'b11 gives 0 wait clocks. With 0 waits and `rdy` high, `done` is high in the clock right after the start clock.
- R4: An access that is not flagged (`slow_rgn`=0) gets 0 programmed waits, whatever the value of `wait_sel`.
- R5: `wait_sel` and `slow_rgn` are sampled only in the clock where a start is accepted. Changing them during the access does not change its length.
- R6: `rdy` has no effect while the programmed wait count is not yet zero.
- R7: Once the programmed count is zero, each clock with `rdy` low adds one stall clock. `done` rises in the first clock at count zero in which `rdy` is high.
- R8: `done` is high for exactly one clock per accepted access, and `stall` is low in that clock.
- R9: A `cyc_start` that arrives while an access is open is ignored. This includes the clock in which `done` is high. After `done`, the block is idle with `stall` and `done` low until a new start.
- R10: `stall` stays high continuously from the clock after an accepted start until the clock in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Bus cycle start strobe, one clock wide |
| wait_sel | input | 2 | Wait selector from the status word (00:4, 01:2, 10:1, 11:0) |
| slow_rgn | input | 1 | Address decoder flag: the access targets a slow region |
| rdy | input | 1 | External ready; low stretches the cycle once the programmed waits are used up |
| stall | output | 1 | Hold request to the bus cycle sequencer |
| done | output | 1 | One-clock pulse marking the last clock of the access |

## Verification
The assertions assume that `cyc_start`, `wait_sel`, `slow_rgn` and `rdy` are synchronous to `clk` and carry known values from reset onward. They also assume that `done` may follow `rdy` within the same clock. The bench therefore changes every input just after the falling edge, sets `rdy` before it reads `done`, and leaves one settle step in between. Selector and flag are deliberately inverted after every start strobe, so that the capture rule is exercised in every access rather than in a single test.

// File: rtl/wstretch_pkg.sv
package wstretch_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_OPEN = 1'b1
    } phase_e;

    localparam int SEL_W   = 2;
    localparam int SEL_NUM = 1 << SEL_W;

endpackage

// File: rtl/wstretch_decode.sv
module wstretch_decode
    import wstretch_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter logic [SEL_NUM*CNT_W-1:0] WAIT_TABLE = '0
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             slow,
    output logic [CNT_W-1:0] load
);

    logic [CNT_W-1:0] entry [SEL_NUM];

    generate
        for (genvar g = 0; g < SEL_NUM; g++) begin : g_entry
            assign entry[g] = WAIT_TABLE[g*CNT_W +: CNT_W];
        end
    endgenerate

    always_comb begin
        if (slow) begin
            load = entry[sel];
        end else begin
            load = '0;
        end
    end

    always_comb begin
        if (!slow) begin
            p_unflagged_zero_r4: assert (load == '0);
        end
    end

endmodule

// File: rtl/wstretch_seq.sv
module wstretch_seq
    import wstretch_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    input  logic             rdy,
    output logic             stall,
    output logic             done
);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t r_q, r_d;
    logic stall_c, done_c;

    always_comb begin
        r_d     = r_q;
        stall_c = 1'b0;
        done_c  = 1'b0;
        case (r_q.ph)
            PH_IDLE: begin
                if (start) begin
                    r_d.ph  = PH_OPEN;
                    r_d.cnt = load;
                end
            end
            PH_OPEN: begin
                if (r_q.cnt != '0) begin
                    stall_c = 1'b1;
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (rdy) begin
                    done_c = 1'b1;
                    r_d.ph = PH_IDLE;
                end else begin
                    stall_c = 1'b1;
                end
            end
            default: begin
                r_d.ph  = PH_IDLE;
                r_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ph  <= PH_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign stall = stall_c;
    assign done  = done_c;

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && stall));

    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!stall && !done));

    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_OPEN && r_q.cnt != '0) |=>
            (r_q.ph == PH_OPEN && r_q.cnt == $past(r_q.cnt) - 1'b1));

    p_rdy_extends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_OPEN && r_q.cnt == '0 && !rdy) |=> (r_q.ph == PH_OPEN));

    p_start_opens_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_IDLE && start) |=> (stall || done));

    p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_OPEN && r_q.cnt != '0 && start) |=> $stable(r_q.ph));

endmodule

// File: rtl/wait_stretch.sv
module wait_stretch
    import wstretch_pkg::*;
#(
    parameter int CNT_W      = 3,
    parameter int WAITS_SEL0 = 4,
    parameter int WAITS_SEL1 = 2,
    parameter int WAITS_SEL2 = 1,
    parameter int WAITS_SEL3 = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_start,
    input  logic [1:0] wait_sel,
    input  logic       slow_rgn,
    input  logic       rdy,
    output logic       stall,
    output logic       done
);

    localparam logic [SEL_NUM*CNT_W-1:0] TABLE = {
        CNT_W'(WAITS_SEL3), CNT_W'(WAITS_SEL2),
        CNT_W'(WAITS_SEL1), CNT_W'(WAITS_SEL0)
    };

    logic [CNT_W-1:0] load_w;

    wstretch_decode #(
        .CNT_W      (CNT_W),
        .WAIT_TABLE (TABLE)
    ) u_decode (
        .sel  (wait_sel),
        .slow (slow_rgn),
        .load (load_w)
    );

    wstretch_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cyc_start),
        .load  (load_w),
        .rdy   (rdy),
        .stall (stall),
        .done  (done)
    );

    p_outputs_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({stall, done}));

endmodule

// File: tb/wait_stretch_test.sv
module wait_stretch_test;

    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic [1:0] sel;
        logic       slow;
        logic [3:0] waits;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{sel: 2'b00, slow: 1'b1, waits: 4'd4},
        '{sel: 2'b01, slow: 1'b1, waits: 4'd2},
        '{sel: 2'b10, slow: 1'b1, waits: 4'd1},
        '{sel: 2'b11, slow: 1'b1, waits: 4'd0},
        '{sel: 2'b00, slow: 1'b0, waits: 4'd0},
        '{sel: 2'b01, slow: 1'b0, waits: 4'd0},
        '{sel: 2'b10, slow: 1'b0, waits: 4'd0},
        '{sel: 2'b11, slow: 1'b0, waits: 4'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0;
    logic [1:0] wait_sel = 2'b00;
    logic       slow_rgn = 1'b0;
    logic       rdy = 1'b1;
    logic       stall;
    logic       done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wait_stretch uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .wait_sel  (wait_sel),
        .slow_rgn  (slow_rgn),
        .rdy       (rdy),
        .stall     (stall),
        .done      (done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One access; selector and flag are inverted after the start clock (R5).
    task automatic access(input logic [1:0] s, input logic sl,
                          input int lo_from, input int lo_len, input int poke_at,
                          output int waits, output int gaps,
                          output int stall_at_done, output int busy_after);
        @(negedge clk);
        cyc_start = 1'b1; wait_sel = s; slow_rgn = sl; rdy = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0; wait_sel = ~s; slow_rgn = ~sl;
        waits = 0; gaps = 0;
        for (int j = 0; j < 64; j++) begin
            rdy = !(j >= lo_from && j < lo_from + lo_len);
            cyc_start = (j == poke_at);
            #1;
            if (done) break;
            if (!stall) gaps++;
            waits++;
            @(negedge clk);
        end
        stall_at_done = int'(stall);
        @(negedge clk);
        cyc_start = 1'b0; rdy = 1'b1;
        #1;
        busy_after = int'(stall | done);
    endtask

    initial begin
        int w, g, sd, ba;
        #1;
        check("R1 stall in reset", int'(stall), 0);
        check("R1 done in reset", int'(done), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stall after reset", int'(stall), 0);
        check("R1 done after reset", int'(done), 0);

        // Table walk: R2, R3, R4, R5, R8, R10
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].sel, VECS[i].slow, 99, 0, 99, w, g, sd, ba);
            check(VECS[i].slow ? (VECS[i].sel == 2'b00 ? "R2 wait count" : "R3 wait count")
                               : "R4 unflagged wait count", w, int'(VECS[i].waits));
            check("R10 stall continuous", g, 0);
            check("R8 stall low with done", sd, 0);
            check("R8 done single, idle after", ba, 0);
        end

        // R7: ready low after one programmed wait adds three clocks
        access(2'b10, 1'b1, 1, 3, 99, w, g, sd, ba);
        check("R7 extension after count", w, 4);
        check("R10 stall continuous in extension", g, 0);
        // R7: zero programmed waits, ready low two clocks
        access(2'b11, 1'b1, 0, 2, 99, w, g, sd, ba);
        check("R7 extension with zero waits", w, 2);
        // R6: ready low only during the programmed count
        access(2'b00, 1'b1, 0, 4, 99, w, g, sd, ba);
        check("R6 ready ignored during count", w, 4);
        access(2'b00, 1'b1, 2, 2, 99, w, g, sd, ba);
        check("R6 ready ignored mid count", w, 4);
        // R6 + R7: low straddles count end
        access(2'b01, 1'b1, 1, 3, 99, w, g, sd, ba);
        check("R7 straddling ready low", w, 4);
        // R9: start while open, and in the done clock
        access(2'b01, 1'b1, 99, 0, 1, w, g, sd, ba);
        check("R9 start mid access ignored (length)", w, 2);
        check("R9 start mid access ignored (after)", ba, 0);
        access(2'b01, 1'b1, 99, 0, 2, w, g, sd, ba);
        check("R9 start in done clock ignored", ba, 0);
        // R4: unflagged access ignores ready-free length of selector 00
        access(2'b00, 1'b0, 99, 0, 99, w, g, sd, ba);
        check("R4 unflagged selector 00", w, 0);

        // R1: reset in the middle of an access returns to idle
        @(negedge clk);
        cyc_start = 1'b1; wait_sel = 2'b00; slow_rgn = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 stall after mid-access reset", int'(stall), 0);
        check("R1 done after mid-access reset", int'(done), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule